// File: doc/BRIEF.md
# Single-Phase Fan Lock-Protect Commutation Supervisor

This block turns the Hall comparator polarity and an internally generated PWM enable into the four switch enables of a single-phase H-bridge. It also produces the tachometer pull-down and watches tachometer edges to detect a stalled rotor. When a whole drive window passes without a tachometer edge, the bridge goes into a protected state with the high-side switches released. The block stays there for ten times the window length. It then resumes drive and sends a one-cycle restart strobe to the speed regulator.

A prescaler turns the clock into a tick, and both timeouts are whole multiples of that tick. The drive window is `ON_TICKS` ticks and the protected period is `ON_TICKS*OFF_RATIO` ticks, so the 1:10 ratio is exact. The prescaler and the tick counter both restart at every reload event. As a result, a window lasts exactly `ON_TICKS*TICK_DIV` clock cycles after its reload edge. A thermal-shutdown flag overrides everything: it turns every switch off and keeps the supervisor at the start of a fresh drive window.

Top module: `fan_lock_supervisor`

## Requirements
- R1: With `hall_pol`=1 and `pwm_en`=1 while running, the outputs one cycle later are `out1_hi`=1, `out1_lo`=0, `out2_hi`=0, `out2_lo`=1.
- R2: With `hall_pol`=0 and `pwm_en`=1 while running, the outputs one cycle later are `out1_hi`=0, `out1_lo`=1, `out2_hi`=1, `out2_lo`=0.
- R3: With `pwm_en`=0 the bridge regenerates. Both high sides are off, and only the low side of the leg that the polarity pulls low stays on: `out2_lo` when `hall_pol`=1, `out1_lo` when `hall_pol`=0.
- R4: `tach_pull_low` equals the inverse of `hall_pol`, one cycle later.
- R5: If no `tach_edge` is sampled for `ON_TICKS*TICK_DIV` cycles after a reload edge, the supervisor enters lock protection on that edge. From the next cycle on, the high sides are off whatever `pwm_en` is, and the low sides follow the R3 pattern.
- R6: A `tach_edge` sampled while running reloads the drive window. This also holds when it coincides with the window's final tick, and then no lock occurs.
- R7: Lock protection lasts exactly `ON_TICKS*OFF_RATIO*TICK_DIV` cycles, and a `tach_edge` during it does not change that length.
- R8: On the edge that leaves lock protection, `restart_pulse` goes high for exactly one cycle. Normal drive is visible on the following cycle, and a new window starts from that edge.
- R9: While `tsd_flag` is 1, all four switch enables are 0 from the next cycle on. The supervisor stays at the start of a running window, so the window length is counted from the last edge that sampled the flag high.
- R10: During reset all outputs are 0. The first window counts from the release of reset.
- R11: No leg ever has its high and low switches on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_pol | input | 1 | Hall polarity, 1 when input 1 is above input 2 |
| pwm_en | input | 1 | PWM enable from the speed regulator |
| tach_edge | input | 1 | One-cycle pulse per valid tachometer edge |
| tsd_flag | input | 1 | Thermal-shutdown request |
| out1_hi | output | 1 | Leg 1 high-side enable |
| out1_lo | output | 1 | Leg 1 low-side enable |
| out2_hi | output | 1 | Leg 2 high-side enable |
| out2_lo | output | 1 | Leg 2 low-side enable |
| tach_pull_low | output | 1 | Open-drain tachometer pull-down enable |
| restart_pulse | output | 1 | One-cycle strobe on leaving lock protection |

## Verification
A change on `hall_pol`, `pwm_en` or `tsd_flag` shows at the bridge outputs one cycle after the edge that samples it. The state changes on the edge that lands `ON_TICKS*TICK_DIV` cycles after a reload, but the switch enables follow one cycle later. `restart_pulse` is high in the same cycle as the exit edge, one cycle before drive resumes. The scoreboard stamps each expected item with the absolute cycle count since reset release, and the monitor compares it only in that cycle. Every check therefore falls on the last cycle of the old behaviour or the first cycle of the new one.

// File: rtl/fan_sup_pkg.sv
package fan_sup_pkg;
  typedef enum logic {ST_RUN = 1'b0, ST_LOCK = 1'b1} sup_state_t;

  typedef struct packed {
    logic hs1;
    logic ls1;
    logic hs2;
    logic ls2;
  } bridge_t;
endpackage

// File: rtl/fan_tick_prescaler.sv
module fan_tick_prescaler #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);

  logic [W-1:0] div_q;

  assign tick = (div_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  div_q <= '0;
    else if (tick)   div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/fan_lock_timer.sv
module fan_lock_timer
  import fan_sup_pkg::*;
#(
  parameter int ON_TICKS  = 150000,
  parameter int OFF_TICKS = 1500000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       tach_edge,
  input  logic       tsd,
  output sup_state_t state,
  output logic       reload,
  output logic       restart
);
  localparam int CW = $clog2(OFF_TICKS + 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_TICKS - 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          run_reload;
  logic          expire;

  assign run_reload = (state == ST_RUN) && tach_edge;
  assign expire     = tick && (cnt_q == ((state == ST_RUN) ? ON_LAST : OFF_LAST));
  assign reload     = tsd || run_reload || expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RUN;
      cnt_q   <= '0;
      restart <= 1'b0;
    end else begin
      restart <= 1'b0;
      if (tsd) begin
        state <= ST_RUN;
        cnt_q <= '0;
      end else if (run_reload) begin
        cnt_q <= '0;
      end else if (expire) begin
        cnt_q   <= '0;
        state   <= (state == ST_RUN) ? ST_LOCK : ST_RUN;
        restart <= (state == ST_LOCK);
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fan_bridge_map.sv
module fan_bridge_map
  import fan_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  sup_state_t state,
  input  logic       hall_pol,
  input  logic       pwm_en,
  input  logic       tsd,
  output bridge_t    legs,
  output logic       tach_low
);
  bridge_t nxt;

  always_comb begin
    nxt = '0;
    if (!tsd) begin
      if (state == ST_RUN && pwm_en) begin
        nxt.hs1 = hall_pol;
        nxt.ls2 = hall_pol;
        nxt.hs2 = !hall_pol;
        nxt.ls1 = !hall_pol;
      end else begin
        nxt.ls2 = hall_pol;
        nxt.ls1 = !hall_pol;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      legs     <= '0;
      tach_low <= 1'b0;
    end else begin
      legs     <= nxt;
      tach_low <= !hall_pol;
    end
  end
endmodule

// File: rtl/fan_lock_supervisor.sv
module fan_lock_supervisor
  import fan_sup_pkg::*;
#(
  parameter int TICK_DIV  = 1000,
  parameter int ON_TICKS  = 150000,
  parameter int OFF_RATIO = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic hall_pol,
  input  logic pwm_en,
  input  logic tach_edge,
  input  logic tsd_flag,
  output logic out1_hi,
  output logic out1_lo,
  output logic out2_hi,
  output logic out2_lo,
  output logic tach_pull_low,
  output logic restart_pulse
);
  localparam int OFF_TICKS = ON_TICKS * OFF_RATIO;

  logic       tick;
  logic       reload;
  sup_state_t state;
  bridge_t    legs;
  logic       in_lock;

  assign in_lock = (state == ST_LOCK);

  fan_tick_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst(rst), .clr(reload), .tick(tick)
  );

  fan_lock_timer #(.ON_TICKS(ON_TICKS), .OFF_TICKS(OFF_TICKS)) u_tmr (
    .clk(clk), .rst(rst), .tick(tick), .tach_edge(tach_edge), .tsd(tsd_flag),
    .state(state), .reload(reload), .restart(restart_pulse)
  );

  fan_bridge_map u_map (
    .clk(clk), .rst(rst), .state(state), .hall_pol(hall_pol), .pwm_en(pwm_en),
    .tsd(tsd_flag), .legs(legs), .tach_low(tach_pull_low)
  );

  assign out1_hi = legs.hs1;
  assign out1_lo = legs.ls1;
  assign out2_hi = legs.hs2;
  assign out2_lo = legs.ls2;
endmodule

// File: rtl/fan_sup_chk.sv
module fan_sup_chk (
  input logic clk,
  input logic rst,
  input logic pwm_en,
  input logic tsd_flag,
  input logic in_lock,
  input logic out1_hi,
  input logic out1_lo,
  input logic out2_hi,
  input logic out2_lo,
  input logic restart_pulse
);
  // R11
  leg_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(out1_hi && out1_lo) && !(out2_hi && out2_lo));

  // R9
  tsd_all_off_chk: assert property (@(posedge clk) disable iff (rst)
    tsd_flag |=> !(out1_hi || out1_lo || out2_hi || out2_lo));

  // R3
  pwm_low_no_high_chk: assert property (@(posedge clk) disable iff (rst)
    !pwm_en |=> !out1_hi && !out2_hi);

  // R8
  restart_single_chk: assert property (@(posedge clk) disable iff (rst)
    restart_pulse |=> !restart_pulse);

  // R8
  restart_from_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(restart_pulse) |-> $past(in_lock));
endmodule

bind fan_lock_supervisor fan_sup_chk u_chk (
  .clk(clk), .rst(rst), .pwm_en(pwm_en), .tsd_flag(tsd_flag), .in_lock(in_lock),
  .out1_hi(out1_hi), .out1_lo(out1_lo), .out2_hi(out2_hi), .out2_lo(out2_lo),
  .restart_pulse(restart_pulse)
);

// File: tb/tb_fan_lock_supervisor.sv
module tb_fan_lock_supervisor;
  typedef struct {
    int         cyc;
    logic [5:0] val;
    string      req;
  } exp_t;

  logic clk = 0, rst = 1;
  logic hall_pol = 1, pwm_en = 1, tach_edge = 0, tsd_flag = 0;
  logic out1_hi, out1_lo, out2_hi, out2_lo, tach_pull_low, restart_pulse;
  int cyc = 0;
  int checks = 0, fails = 0;
  bit done = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  fan_lock_supervisor #(.TICK_DIV(4), .ON_TICKS(5), .OFF_RATIO(10)) dut (
    .clk(clk), .rst(rst), .hall_pol(hall_pol), .pwm_en(pwm_en),
    .tach_edge(tach_edge), .tsd_flag(tsd_flag),
    .out1_hi(out1_hi), .out1_lo(out1_lo), .out2_hi(out2_hi), .out2_lo(out2_lo),
    .tach_pull_low(tach_pull_low), .restart_pulse(restart_pulse)
  );

  wire [5:0] obs = {out1_hi, out1_lo, out2_hi, out2_lo, tach_pull_low, restart_pulse};

  always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

  task automatic push(input int c, input logic [5:0] v, input string r);
    exp_t e;
    e.cyc = c; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc != n) @(negedge clk);
  endtask

  // monitor: compares scoreboard items in their due cycle
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if ((out1_hi && out1_lo) || (out2_hi && out2_lo)) begin
        fails++;
        $display("FAIL R11 cyc %0d: legs %b expected no leg with both switches on", cyc, obs[5:2]);
      end
      while (q.size() > 0 && q[0].cyc == cyc) begin
        checks++;
        if (obs !== q[0].val) begin
          fails++;
          $display("FAIL %s cyc %0d: got %b expected %b", q[0].req, cyc, obs, q[0].val);
        end
        void'(q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // order {hi1,lo1,hi2,lo2,tach_pull_low,restart}
    push(1,   6'b100100, "R1");
    push(9,   6'b011010, "R2");
    push(11,  6'b010010, "R3");
    push(13,  6'b000100, "R3");
    push(15,  6'b100100, "R1");
    push(36,  6'b100100, "R6");
    push(37,  6'b000100, "R5");
    push(60,  6'b000100, "R7");
    push(235, 6'b000100, "R7");
    push(236, 6'b000101, "R8");
    push(237, 6'b100100, "R8");
    push(255, 6'b100100, "R5");
    push(257, 6'b000100, "R5");
    push(265, 6'b000000, "R9");
    push(271, 6'b100100, "R9");
    push(290, 6'b100100, "R6");
    push(310, 6'b100100, "R6");
    push(311, 6'b000100, "R6");

    repeat (3) @(negedge clk);
    checks++;
    if (obs !== 6'b0) begin
      fails++;
      $display("FAIL R10 reset: got %b expected 000000", obs);
    end
    rst = 0;
    wait_cyc(5);   tach_edge = 1; @(negedge clk); tach_edge = 0;
    wait_cyc(8);   hall_pol = 0;   // R2, R4
    wait_cyc(10);  pwm_en = 0;     // R3
    wait_cyc(12);  hall_pol = 1;
    wait_cyc(14);  pwm_en = 1;
    wait_cyc(15);  tach_edge = 1; @(negedge clk); tach_edge = 0;   // R6 reload at 16
    wait_cyc(50);  tach_edge = 1; @(negedge clk); tach_edge = 0;   // R7 ignored in lock
    wait_cyc(260); tsd_flag = 1;   // R9
    wait_cyc(270); tsd_flag = 0;
    wait_cyc(289); tach_edge = 1; @(negedge clk); tach_edge = 0;  // R6 edge at expiry
    wait_cyc(320);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: got %0d pending expected 0", q.size());
    end
    finish_run();
  end
endmodule